// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block is the clocked control logic that sits between a PWM controller and the two gate drivers of a synchronous buck power stage. Each clock it takes an already-digitized three-level PWM command, together with an active-low disable, an active-low skip request, a supply-good flag from undervoltage lockout, and two "gate discharged" feedback flags. From these it decides which power switch may conduct. It returns a registered enable for the high-side gate and one for the low-side gate. Alongside them it produces a thermal warning flag with hysteresis, derived from a digitized junction temperature code.

A gate is only switched on once the opposite gate has been commanded off and has reported itself discharged for a fixed number of cycles. A PWM line left floating in its mid band shuts both switches off after a timed hold-off. The hold-off, dead-time and enable-release delays are all given in nanoseconds and converted to clock cycles from the clock period parameter. With the defaults (20 ns clock, 150 ns hold-off, 10 ns dead time, 22 ns release) these come to 8, 1 and 2 cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both gate enables and the thermal flag are low.
- R2: `pwmLvl` is encoded 2'b00 = low, 2'b01 = high, 2'b1x = mid (tri-state). With the stage running and skip inactive, a high command ends with only the high-side enable set, and a low command ends with only the low-side enable set. A gate whose command goes away drops at the next clock edge.
- R3: A gate enable may rise only if the opposite enable was low in the cycle before. In addition, the opposite discharged flag must have been sampled high with that enable low on DEAD_CYC consecutive edges. If the flag stays low, the gate stays off indefinitely.
- R4: While `pwmLvl` is mid, the previous command is kept. Once mid has been sampled on HOLD_CYC consecutive edges, both enables go low at the following edge. A mid pulse of HOLD_CYC-1 cycles changes nothing, and the hold-off count restarts whenever the command leaves the mid band.
- R5: `disableN` low forces both enables low at the next edge, whatever the PWM and skip inputs are. After release, no gate turns on until `disableN` and `supplyOk` have both been high on ENA_CYC consecutive edges.
- R6: `skipN` low keeps the low-side enable low. A high command still turns the high side on, and a low command leaves both gates off.
- R7: `supplyOk` low forces both enables low at the next edge, and a rising supply obeys the same release delay as R5.
- R8: The two gate enables are never high in the same cycle.
- R9: `thermWarn` goes high one edge after `tempCode` exceeds WARN_SET and goes low one edge after it falls below WARN_CLR. Between the two limits it holds its value. It has no effect on the gate enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmLvl | input | 2 | Digitized PWM command: 00 low, 01 high, 1x mid band |
| disableN | input | 1 | Active-low stage disable (low when open) |
| skipN | input | 1 | Active-low skip request, low side held off (high when open) |
| supplyOk | input | 1 | Undervoltage lockout reports supply good |
| hiOffFb | input | 1 | High-side gate reads discharged |
| loOffFb | input | 1 | Low-side gate reads discharged |
| tempCode | input | TEMP_W | Junction temperature code in degrees C |
| hiGateEn | output | 1 | High-side gate enable |
| loGateEn | output | 1 | Low-side gate enable |
| thermWarn | output | 1 | Over-temperature warning with hysteresis |

## Verification
Steady PWM levels held for every combination of disable, skip and command level show that the final gate state follows the truth table. Alternating and single-cycle PWM pulses show that the dead-time interlock, not the command, limits how fast the gates can swap. Mid-band pulses of HOLD_CYC-1 and HOLD_CYC cycles, with a short excursion between them, tell a correct restart of the hold-off count from one that accumulates across pulses. Stuck-low discharge feedback, disable and lockout drops during switching, and a temperature sweep through both thresholds each isolate one forcing path. Long mixed random sequences then confirm the interlock and the mutual exclusion under arbitrary timing.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // resolved command the controller is acting on
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_HI   = 2'd1,
    CMD_LO   = 2'd2
  } cmd_e;

  // control -> datapath strobes
  typedef struct packed {
    logic pwmTri;   // command is in the mid band this cycle
    logic runArm;   // disable released and supply good
    logic hiOn;     // current high-side enable
    logic loOn;     // current low-side enable
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic holdExpired;  // mid band held for the full hold-off
    logic runReady;     // release delay has elapsed
    logic hiPathClear;  // low side proven off long enough
    logic loPathClear;  // high side proven off long enough
  } dpStatus_t;

endpackage

// File: rtl/hb_sat_cnt.sv
module hb_sat_cnt #(
  parameter int LIMIT = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic countEn,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  // counts consecutive enabled edges, clears on any gap, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (!countEn)    cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/hb_gate_dp.sv
module hb_gate_dp
  import hb_gate_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int DEAD_CYC = 1,
  parameter int ENA_CYC  = 2,
  parameter int TEMP_W   = 8,
  parameter int WARN_SET = 160,
  parameter int WARN_CLR = 135
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              hiOffFb,
  input  logic              loOffFb,
  input  logic [TEMP_W-1:0] tempCode,
  output dpStatus_t         stat,
  output logic              thermWarn
);
  localparam logic [TEMP_W-1:0] SET_LIM = TEMP_W'(WARN_SET);
  localparam logic [TEMP_W-1:0] CLR_LIM = TEMP_W'(WARN_CLR);

  // mid-band hold-off timer
  hb_sat_cnt #(.LIMIT(HOLD_CYC)) u_holdCnt (
    .clk(clk), .rstN(rstN), .countEn(strb.pwmTri), .done(stat.holdExpired)
  );

  // release delay after disable / lockout
  hb_sat_cnt #(.LIMIT(ENA_CYC)) u_readyCnt (
    .clk(clk), .rstN(rstN), .countEn(strb.runArm), .done(stat.runReady)
  );

  // dead-time qualifiers, index 0 clears the high side, 1 the low side
  logic [1:0] oppOff;
  logic [1:0] pathClr;
  assign oppOff[0] = !strb.loOn && loOffFb;
  assign oppOff[1] = !strb.hiOn && hiOffFb;

  for (genvar g = 0; g < 2; g++) begin : g_dead
    hb_sat_cnt #(.LIMIT(DEAD_CYC)) u_deadCnt (
      .clk(clk), .rstN(rstN), .countEn(oppOff[g]), .done(pathClr[g])
    );
  end

  assign stat.hiPathClear = pathClr[0];
  assign stat.loPathClear = pathClr[1];

  // thermal flag with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    thermWarn <= 1'b0;
    else if (tempCode > SET_LIM)  thermWarn <= 1'b1;
    else if (tempCode < CLR_LIM)  thermWarn <= 1'b0;
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  pwmLvl,
  input  logic        disableN,
  input  logic        skipN,
  input  logic        supplyOk,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        hiGateEn,
  output logic        loGateEn
);
  cmd_e lastCmd;
  cmd_e effCmd;
  logic forceOff;
  logic hiNext;
  logic loNext;

  always_comb begin
    if (pwmLvl[1])      effCmd = lastCmd;  // mid band keeps prior command
    else if (pwmLvl[0]) effCmd = CMD_HI;
    else                effCmd = CMD_LO;

    forceOff = !supplyOk || !disableN || !stat.runReady || stat.holdExpired;

    hiNext = !forceOff && (effCmd == CMD_HI) &&
             (hiGateEn || (stat.hiPathClear && !loGateEn));
    loNext = !forceOff && skipN && (effCmd == CMD_LO) &&
             (loGateEn || (stat.loPathClear && !hiGateEn));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCmd  <= CMD_IDLE;
      hiGateEn <= 1'b0;
      loGateEn <= 1'b0;
    end else begin
      lastCmd  <= effCmd;
      hiGateEn <= hiNext;
      loGateEn <= loNext;
    end
  end

  assign strb.pwmTri = pwmLvl[1];
  assign strb.runArm = disableN && supplyOk;
  assign strb.hiOn   = hiGateEn;
  assign strb.loOn   = loGateEn;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int HOLD_NS  = 150,
  parameter int DEAD_NS  = 10,
  parameter int ENA_NS   = 22,
  parameter int TEMP_W   = 8,
  parameter int WARN_SET = 160,
  parameter int WARN_CLR = 135
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwmLvl,
  input  logic              disableN,
  input  logic              skipN,
  input  logic              supplyOk,
  input  logic              hiOffFb,
  input  logic              loOffFb,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              hiGateEn,
  output logic              loGateEn,
  output logic              thermWarn
);
  localparam int HOLD_RAW = (HOLD_NS + CLK_NS - 1) / CLK_NS;
  localparam int DEAD_RAW = (DEAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int ENA_RAW  = (ENA_NS + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int DEAD_CYC = (DEAD_RAW < 1) ? 1 : DEAD_RAW;
  localparam int ENA_CYC  = (ENA_RAW < 1) ? 1 : ENA_RAW;

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  hb_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwmLvl(pwmLvl), .disableN(disableN),
    .skipN(skipN), .supplyOk(supplyOk), .stat(stat), .strb(strb),
    .hiGateEn(hiGateEn), .loGateEn(loGateEn)
  );

  hb_gate_dp #(
    .HOLD_CYC(HOLD_CYC), .DEAD_CYC(DEAD_CYC), .ENA_CYC(ENA_CYC),
    .TEMP_W(TEMP_W), .WARN_SET(WARN_SET), .WARN_CLR(WARN_CLR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hiOffFb(hiOffFb),
    .loOffFb(loOffFb), .tempCode(tempCode), .stat(stat),
    .thermWarn(thermWarn)
  );
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int TEMP_W   = 8,
  parameter int WARN_SET = 160,
  parameter int WARN_CLR = 135
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        pwmLvl,
  input logic              disableN,
  input logic              skipN,
  input logic              supplyOk,
  input logic              hiOffFb,
  input logic              loOffFb,
  input logic [TEMP_W-1:0] tempCode,
  input logic              hiGateEn,
  input logic              loGateEn,
  input logic              thermWarn
);
  AST_NEVER_BOTH_ON: assert property (@(posedge clk) disable iff (!rstN)
    !(hiGateEn && loGateEn)); // R8

  AST_PWM_LOW_NO_HI: assert property (@(posedge clk) disable iff (!rstN)
    (pwmLvl == 2'b00) |=> !hiGateEn); // R2

  AST_HI_INTERLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiGateEn) |-> (!$past(loGateEn) && $past(loOffFb, 2))); // R3

  AST_LO_INTERLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loGateEn) |-> (!$past(hiGateEn) && $past(hiOffFb, 2))); // R3

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !disableN |=> (!hiGateEn && !loGateEn)); // R5

  AST_SKIP_LO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !skipN |=> !loGateEn); // R6

  AST_LOCKOUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!hiGateEn && !loGateEn)); // R7

  AST_THERM_SET: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode > TEMP_W'(WARN_SET)) |=> thermWarn); // R9

  AST_THERM_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode < TEMP_W'(WARN_CLR)) |=> !thermWarn); // R9
endmodule

bind hb_gate_seq hb_gate_chk #(
  .TEMP_W(TEMP_W), .WARN_SET(WARN_SET), .WARN_CLR(WARN_CLR)
) u_chk (
  .clk(clk), .rstN(rstN), .pwmLvl(pwmLvl), .disableN(disableN),
  .skipN(skipN), .supplyOk(supplyOk), .hiOffFb(hiOffFb), .loOffFb(loOffFb),
  .tempCode(tempCode), .hiGateEn(hiGateEn), .loGateEn(loGateEn),
  .thermWarn(thermWarn)
);

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;
  // cycle counts worked out from 20 ns clock: 150/20 -> 8, 10/20 -> 1, 22/20 -> 2
  localparam int HOLD = 8;
  localparam int DEAD = 1;
  localparam int ENA  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic [1:0] pwmLvl = 2'b00;
  logic       disableN = 1'b0;
  logic       skipN = 1'b1;
  logic       supplyOk = 1'b0;
  logic       hiOffFb = 1'b1;
  logic       loOffFb = 1'b1;
  logic [7:0] tempCode = 8'd25;
  logic       hiGateEn, loGateEn, thermWarn;

  hb_gate_seq i_hb_gate_seq (
    .clk(clk), .rstN(rstN), .pwmLvl(pwmLvl), .disableN(disableN),
    .skipN(skipN), .supplyOk(supplyOk), .hiOffFb(hiOffFb), .loOffFb(loOffFb),
    .tempCode(tempCode), .hiGateEn(hiGateEn), .loGateEn(loGateEn),
    .thermWarn(thermWarn)
  );

  int testCnt = 0;
  int failCnt = 0;

  // reference model state
  int   mTri = 0, mRdy = 0, mHiClr = 0, mLoClr = 0, mLast = 0;
  logic mHi = 1'b0, mLo = 1'b0, mTh = 1'b0;
  bit   hiStuck = 0, loStuck = 0, randFb = 0;

  task automatic chk(string tag, logic act, logic exp, string what);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic int satInc(int v, int lim);
    return (v + 1 > lim) ? lim : v + 1;
  endfunction

  // one clock: drive feedback, advance model, compare after the edge
  task automatic cyc(string tag);
    int   eff;
    logic off, nHi, nLo;
    hiOffFb = hiStuck ? 1'b0 : (!hiGateEn && (!randFb || $urandom_range(0, 3) != 0));
    loOffFb = loStuck ? 1'b0 : (!loGateEn && (!randFb || $urandom_range(0, 3) != 0));
    eff = pwmLvl[1] ? mLast : (pwmLvl[0] ? 1 : 2);
    off = !supplyOk || !disableN || (mRdy < ENA) || (mTri >= HOLD);
    nHi = !off && (eff == 1) && (mHi || (mHiClr >= DEAD && !mLo));
    nLo = !off && skipN && (eff == 2) && (mLo || (mLoClr >= DEAD && !mHi));
    mHiClr = (!mLo && loOffFb) ? satInc(mHiClr, DEAD) : 0;
    mLoClr = (!mHi && hiOffFb) ? satInc(mLoClr, DEAD) : 0;
    mTri   = pwmLvl[1] ? satInc(mTri, HOLD) : 0;
    mRdy   = (disableN && supplyOk) ? satInc(mRdy, ENA) : 0;
    mLast  = eff;
    if (tempCode > 8'd160)      mTh = 1'b1;
    else if (tempCode < 8'd135) mTh = 1'b0;
    mHi = nHi;
    mLo = nLo;
    @(posedge clk);
    @(negedge clk);
    chk(tag, hiGateEn, mHi, "hiGateEn vs model");
    chk(tag, loGateEn, mLo, "loGateEn vs model");
    chk(tag, thermWarn, mTh, "thermWarn vs model");
    chk("R8", hiGateEn && loGateEn, 1'b0, "both gates on");
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", hiGateEn, 1'b0, "hi in reset");
    chk("R1", loGateEn, 1'b0, "lo in reset");
    chk("R1", thermWarn, 1'b0, "warn in reset");
    disableN = 1'b1; supplyOk = 1'b1; pwmLvl = 2'b01;
    rstN = 1'b1;
    cyc("R1");
    chk("R1", hiGateEn, 1'b0, "hi first cycle after reset");

    // R2: start up and settle high, then alternate
    run("R2", 6);
    chk("R2", hiGateEn, 1'b1, "hi after high command");
    pwmLvl = 2'b00; run("R2", 5);
    chk("R2", loGateEn, 1'b1, "lo after low command");
    chk("R2", hiGateEn, 1'b0, "hi after low command");
    for (int k = 0; k < 6; k++) begin
      pwmLvl = 2'b01; run("R2", 4);
      pwmLvl = 2'b00; run("R2", 4);
    end
    for (int k = 0; k < 8; k++) begin      // single-cycle pulses
      pwmLvl = k[0] ? 2'b01 : 2'b00; run("R3", 1);
    end
    pwmLvl = 2'b00; run("R3", 4);

    // R3: discharged flag stuck low blocks turn-on
    loStuck = 1; pwmLvl = 2'b01; run("R3", 6);
    chk("R3", hiGateEn, 1'b0, "hi with lo flag stuck");
    chk("R3", loGateEn, 1'b0, "lo dropped on high command");
    loStuck = 0; run("R3", 1);
    chk("R3", hiGateEn, 1'b0, "hi before dead time");
    run("R3", 1);
    chk("R3", hiGateEn, 1'b1, "hi after dead time");

    // R4: mid pulse one short of hold-off keeps state, restart, then expiry
    pwmLvl = 2'b10; run("R4", HOLD - 1);
    chk("R4", hiGateEn, 1'b1, "hi held during short mid pulse");
    pwmLvl = 2'b01; run("R4", 1);
    pwmLvl = 2'b11; run("R4", HOLD - 1);
    chk("R4", hiGateEn, 1'b1, "hold-off count restarted");
    pwmLvl = 2'b01; run("R4", 2);
    pwmLvl = 2'b10; run("R4", HOLD);
    chk("R4", hiGateEn, 1'b1, "hi still on at hold-off edge");
    run("R4", 1);
    chk("R4", hiGateEn, 1'b0, "hi off after hold-off");
    chk("R4", loGateEn, 1'b0, "lo off after hold-off");
    pwmLvl = 2'b00; run("R4", 4);
    chk("R4", loGateEn, 1'b1, "lo resumes after mid exit");

    // R5: disable drop and release delay
    pwmLvl = 2'b01; run("R5", 4);
    disableN = 1'b0; run("R5", 1);
    chk("R5", hiGateEn, 1'b0, "hi off on disable");
    run("R5", 3);
    disableN = 1'b1; run("R5", ENA);
    chk("R5", hiGateEn, 1'b0, "hi held during release delay");
    run("R5", 1);
    chk("R5", hiGateEn, 1'b1, "hi after release delay");

    // R7: lockout drop and recovery
    supplyOk = 1'b0; run("R7", 1);
    chk("R7", hiGateEn, 1'b0, "hi off on lockout");
    pwmLvl = 2'b00; run("R7", 3);
    chk("R7", loGateEn, 1'b0, "lo held off in lockout");
    supplyOk = 1'b1; run("R7", ENA);
    chk("R7", loGateEn, 1'b0, "lo held during release delay");
    run("R7", 1);
    chk("R7", loGateEn, 1'b1, "lo after release delay");

    // R6: skip mode
    skipN = 1'b0; run("R6", 1);
    chk("R6", loGateEn, 1'b0, "lo off on skip");
    pwmLvl = 2'b01; run("R6", 3);
    chk("R6", hiGateEn, 1'b1, "hi still switches in skip");
    pwmLvl = 2'b00; run("R6", 3);
    chk("R6", hiGateEn, 1'b0, "hi off on low in skip");
    chk("R6", loGateEn, 1'b0, "lo off on low in skip");
    skipN = 1'b1; run("R6", 3);
    chk("R6", loGateEn, 1'b1, "lo back after skip release");

    // R9: thermal sweep while switching
    tempCode = 8'd100; pwmLvl = 2'b01; run("R9", 3);
    chk("R9", thermWarn, 1'b0, "warn at 100");
    tempCode = 8'd160; run("R9", 1);
    chk("R9", thermWarn, 1'b0, "warn at set limit");
    tempCode = 8'd161; run("R9", 1);
    chk("R9", thermWarn, 1'b1, "warn above set");
    chk("R9", hiGateEn, 1'b1, "switching continues with warn");
    tempCode = 8'd135; pwmLvl = 2'b00; run("R9", 4);
    chk("R9", thermWarn, 1'b1, "warn held at clear limit");
    chk("R9", loGateEn, 1'b1, "lo switches with warn");
    tempCode = 8'd134; run("R9", 1);
    chk("R9", thermWarn, 1'b0, "warn cleared below clear");
    tempCode = 8'd150; run("R9", 2);
    chk("R9", thermWarn, 1'b0, "warn stays clear in band");
    tempCode = 8'd200; run("R9", 1);
    chk("R9", thermWarn, 1'b1, "warn at 200");
    tempCode = 8'd40; run("R9", 1);

    // truth table over disable, skip and command level
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 3; p++) begin
          logic expHi, expLo;
          disableN = d[0]; skipN = s[0];
          pwmLvl = (p == 2) ? 2'b10 : ((p == 1) ? 2'b01 : 2'b00);
          run("R2", HOLD + ENA + 4);
          expHi = d[0] && (p == 1);
          expLo = d[0] && s[0] && (p == 0);
          chk("R2", hiGateEn, expHi, "truth table hi");
          chk("R5", loGateEn, expLo, "truth table lo");
        end
      end
    end

    // mixed random sequences, R3 and R8 under arbitrary timing
    randFb = 1; disableN = 1'b1; skipN = 1'b1; supplyOk = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 40)      pwmLvl = 2'b01;
      else if (r < 80) pwmLvl = 2'b00;
      else if (r < 92) pwmLvl = 2'b10;
      if ($urandom_range(0, 49) == 0) disableN = ~disableN;
      if ($urandom_range(0, 59) == 0) supplyOk = ~supplyOk;
      if ($urandom_range(0, 39) == 0) skipN = ~skipN;
      if ($urandom_range(0, 29) == 0) tempCode = 8'($urandom_range(120, 175));
      hiStuck = ($urandom_range(0, 19) == 0);
      loStuck = ($urandom_range(0, 19) == 0);
      cyc("R3");
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule